// File: doc/BRIEF.md
# Single-Wire Bus Slave Addressing Controller

This block is the protocol layer of a slave on a single-wire, self-clocked serial bus. A separate bit and byte receiver below it recovers bytes and master acknowledge bits from the line and reports them as one-cycle events. This block watches the raw line level as well. From it, the block detects the long high interval that resets every slave to a waiting state, and it times the quiet gap that must pass before a new command may begin.

On top of those events the controller tracks four modes: idle, standby, active and hold. It checks the synchronisation byte and matches either an 8-bit or a 12-bit device address against configurable family and device codes. It decides after every byte whether the slave drives its acknowledge in the slot that follows the master acknowledge. Command bytes are checked against a parameter table of legal codes, and each legal code has an expected data-byte count. Accepted command and data bytes are handed to the application one cycle after they arrive.

Any protocol error drops the slave into idle, and only a fresh standby interval on the line brings it out again. A master that terminates right after a matching address still receives an acknowledge, so the master can poll for the presence of a device.

Top module: `swb_slave_ctrl`

## Requirements
- R1: After reset the mode is idle (mode_o = 0) and no output pulses. A line that is already high at reset, and has no low-to-high transition, never leaves idle, however long it stays high.
- R2: After a low-to-high transition, TSTBY_CYC consecutive high samples of line_i put the slave in standby (mode_o = 1) from any mode. This includes the middle of a command.
- R3: In standby, a falling edge of line_i starts a command (mode_o = 2) only once GAP_CYC cycles have passed since standby was entered. An earlier falling edge is ignored, and the mode stays 1.
- R4: The first byte of a command must be 8'h55, and the master acknowledge after it must be 1. No slave acknowledge follows it. Any other byte, or a terminate (mak_i = 0), sends the slave to idle.
- R5: With EXT_ADDR = 0, the address byte carries the family code in bits 7:4 and the device code in bits 3:0. It matches when bits 7:4 equal fam_i and bits 3:0 equal dev_i[3:0]. Bits 7:4 equal to 4'hF, or any mismatch, send the slave to idle with no acknowledge.
- R6: With EXT_ADDR = 1, the first address byte must be {4'hF, fam_i}, and no acknowledge follows it. The second byte must equal dev_i, and an acknowledge follows it. A mismatch in either byte sends the slave to idle.
- R7: When the address matches and the master acknowledge after it is 0, the slave acknowledges and returns to standby.
- R8: A command byte that appears in CMD_CODES pulses cmd_vld_o with the byte on byte_o and is acknowledged. Any other byte sends the slave to idle with no acknowledge. The default table, as code(data count), is 03(2), 06(0), 6C(1) and 96(3), with entry i at CMD_CODES[8i+7:8i] and CMD_LENS[4i+3:4i].
- R9: Each data byte pulses dat_vld_o with the byte on byte_o and is acknowledged after a master acknowledge of 1. A data byte beyond the command's table count sends the slave to idle, with no pulse.
- R10: A terminate (mak_i = 0) after exactly the table count of data bytes gives an acknowledge and a cmd_done_o pulse in the same cycle, and puts the slave in standby. A terminate with fewer data bytes sends the slave to idle with no acknowledge.
- R11: edge_miss_i in any active mode other than hold sends the slave to idle.
- R12: hold_i during an acknowledge slot gives hold (mode_o = 3). While in hold, edge_miss_i and a master acknowledge of 0 are ignored. A master acknowledge of 1 leaves hold and completes the pending acknowledge normally.
- R13: sak_o pulses in the cycle after the mak_vld_i it answers. cmd_vld_o and dat_vld_o pulse in the cycle after the byte_vld_i that carried the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised bus line level |
| byte_vld_i | input | 1 | Byte received, one-cycle pulse |
| byte_i | input | 8 | Received byte |
| mak_vld_i | input | 1 | Master acknowledge bit received, one-cycle pulse |
| mak_i | input | 1 | Master acknowledge value: 1 continue, 0 terminate |
| edge_miss_i | input | 1 | Bit layer missed a mandatory mid-bit edge |
| hold_i | input | 1 | Line held low through an acknowledge slot |
| fam_i | input | 4 | Configured family code |
| dev_i | input | 8 | Configured device code; the low nibble is used for 8-bit addressing |
| mode_o | output | 2 | 0 idle, 1 standby, 2 active, 3 hold |
| sak_o | output | 1 | Drive the slave acknowledge in the next slot |
| cmd_vld_o | output | 1 | Accepted command byte on byte_o |
| dat_vld_o | output | 1 | Accepted data byte on byte_o |
| byte_o | output | 8 | Byte handed to the application |
| cmd_done_o | output | 1 | Command terminated at the correct byte count |

## Verification
Every acknowledge is due exactly one cycle after the master acknowledge pulse it answers. Every command or data handover is due one cycle after its byte pulse. The driver stamps each expected event with that cycle number, and the monitor rejects any pulse that comes early, late, unannounced or with the wrong byte. Mode changes from the line take effect on the clock that samples the TSTBY_CYC-th high level, or the first falling edge after the gap. The bench reads the mode a few cycles clear of those edges and also probes just before the standby threshold.

// File: rtl/swb_slv_pkg.sv
package swb_slv_pkg;

   typedef enum logic [1:0] {
      MD_IDLE = 2'd0,
      MD_STBY = 2'd1,
      MD_ACTV = 2'd2,
      MD_HOLD = 2'd3
   } swb_mode_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_STBY,
      S_SYNC,
      S_SYNC_ACK,
      S_ADR1,
      S_ADR1_ACK,
      S_ADR2,
      S_ADR_ACK,
      S_CMD,
      S_XFER_ACK,
      S_DAT
   } swb_state_e;

   localparam logic [7:0] SYNC_PATTERN = 8'h55;
   localparam logic [3:0] ESC_FAMILY   = 4'hF;

endpackage

// File: rtl/swb_line_mon.sv
module swb_line_mon #(
   parameter int TSTBY_CYC = 600,
   parameter int GAP_CYC   = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic in_stby_i,
   output logic stby_evt_o,
   output logic start_o
);
   localparam int HW = $clog2(TSTBY_CYC + 1);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam logic [HW-1:0] HI_MAX  = HW'(TSTBY_CYC);
   localparam logic [GW-1:0] GAP_MAX = GW'(GAP_CYC);

   logic          line_q, armed_q;
   logic [HW-1:0] hi_cnt;
   logic [GW-1:0] gap_cnt;
   logic          rise, fall, count_en;

   assign rise     = line_i & ~line_q;
   assign fall     = ~line_i & line_q;
   assign count_en = line_i & (armed_q | rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b1;
         armed_q <= 1'b0;
         hi_cnt  <= '0;
         gap_cnt <= '0;
      end else begin
         line_q <= line_i;
         if (rise) armed_q <= 1'b1;
         if (!line_i)                          hi_cnt <= '0;
         else if (count_en && hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
         if (!in_stby_i)               gap_cnt <= '0;
         else if (gap_cnt != GAP_MAX)  gap_cnt <= gap_cnt + 1'b1;
      end
   end

   assign stby_evt_o = count_en && (hi_cnt == HI_MAX - 1'b1);
   assign start_o    = fall && in_stby_i && (gap_cnt == GAP_MAX);

   a_r2_stby_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      stby_evt_o |-> (line_i && $past(line_i)));

   a_r3_start_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (in_stby_i && $past(in_stby_i)));

endmodule

// File: rtl/swb_cmd_lut.sv
module swb_cmd_lut #(
   parameter int NUM_CMD = 4,
   parameter int LEN_W   = 4,
   parameter logic [8*NUM_CMD-1:0]     CMD_CODES = 32'h966C0603,
   parameter logic [LEN_W*NUM_CMD-1:0] CMD_LENS  = 16'h3102
) (
   input  logic [7:0]       code_i,
   output logic             hit_o,
   output logic [LEN_W-1:0] len_o
);
   always_comb begin
      hit_o = 1'b0;
      len_o = '0;
      for (int i = 0; i < NUM_CMD; i++) begin
         if (code_i == CMD_CODES[8*i +: 8]) begin
            hit_o = 1'b1;
            len_o = CMD_LENS[LEN_W*i +: LEN_W];
         end
      end
   end
endmodule

// File: rtl/swb_addr_match.sv
module swb_addr_match
   import swb_slv_pkg::*;
#(
   parameter bit EXT_ADDR = 1'b0
) (
   input  logic [7:0] byte_i,
   input  logic [3:0] fam_i,
   input  logic [7:0] dev_i,
   output logic       first_ok_o,
   output logic       first_esc_o,
   output logic       second_ok_o
);
   generate
      if (EXT_ADDR) begin : g_ext
         assign first_ok_o  = 1'b0;
         assign first_esc_o = (byte_i[7:4] == ESC_FAMILY) && (byte_i[3:0] == fam_i);
      end else begin : g_short
         assign first_ok_o  = (byte_i[7:4] != ESC_FAMILY) &&
                              (byte_i[7:4] == fam_i) && (byte_i[3:0] == dev_i[3:0]);
         assign first_esc_o = 1'b0;
      end
   endgenerate

   assign second_ok_o = (byte_i == dev_i);
endmodule

// File: rtl/swb_slave_ctrl.sv
module swb_slave_ctrl
   import swb_slv_pkg::*;
#(
   parameter bit EXT_ADDR  = 1'b0,
   parameter int TSTBY_CYC = 600,
   parameter int GAP_CYC   = 100,
   parameter int NUM_CMD   = 4,
   parameter int LEN_W     = 4,
   parameter logic [8*NUM_CMD-1:0]     CMD_CODES = 32'h966C0603,
   parameter logic [LEN_W*NUM_CMD-1:0] CMD_LENS  = 16'h3102
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_i,
   input  logic       byte_vld_i,
   input  logic [7:0] byte_i,
   input  logic       mak_vld_i,
   input  logic       mak_i,
   input  logic       edge_miss_i,
   input  logic       hold_i,
   input  logic [3:0] fam_i,
   input  logic [7:0] dev_i,
   output logic [1:0] mode_o,
   output logic       sak_o,
   output logic       cmd_vld_o,
   output logic       dat_vld_o,
   output logic [7:0] byte_o,
   output logic       cmd_done_o
);
   generate
      if (TSTBY_CYC < 2) begin : g_bad_tstby
         $error("TSTBY_CYC must be at least 2");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (NUM_CMD < 1 || LEN_W < 1) begin : g_bad_table
         $error("command table needs at least one entry and a nonzero count width");
      end
   endgenerate

   swb_state_e       st_q;
   logic             hold_q;
   logic [LEN_W-1:0] cnt_q;
   logic             stby_evt, start_evt;
   logic             lut_hit;
   logic [LEN_W-1:0] lut_len;
   logic             a1_ok, a1_esc, a2_ok;
   logic             mak_go, miss, in_cmd, ack_slot;

   swb_line_mon #(.TSTBY_CYC(TSTBY_CYC), .GAP_CYC(GAP_CYC)) u_line (
      .clk(clk), .rst_n(rst_n), .line_i(line_i),
      .in_stby_i(st_q == S_STBY),
      .stby_evt_o(stby_evt), .start_o(start_evt));

   swb_cmd_lut #(.NUM_CMD(NUM_CMD), .LEN_W(LEN_W),
                 .CMD_CODES(CMD_CODES), .CMD_LENS(CMD_LENS)) u_lut (
      .code_i(byte_i), .hit_o(lut_hit), .len_o(lut_len));

   swb_addr_match #(.EXT_ADDR(EXT_ADDR)) u_adr (
      .byte_i(byte_i), .fam_i(fam_i), .dev_i(dev_i),
      .first_ok_o(a1_ok), .first_esc_o(a1_esc), .second_ok_o(a2_ok));

   assign in_cmd   = (st_q != S_IDLE) && (st_q != S_STBY);
   assign ack_slot = (st_q == S_SYNC_ACK) || (st_q == S_ADR1_ACK) ||
                     (st_q == S_ADR_ACK)  || (st_q == S_XFER_ACK);
   // in hold only a continue acknowledge is taken; a missed edge counts outside hold
   assign mak_go   = mak_vld_i && (!hold_q || mak_i);
   assign miss     = edge_miss_i && !hold_q && in_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         hold_q     <= 1'b0;
         cnt_q      <= '0;
         sak_o      <= 1'b0;
         cmd_vld_o  <= 1'b0;
         dat_vld_o  <= 1'b0;
         byte_o     <= '0;
         cmd_done_o <= 1'b0;
      end else begin
         sak_o      <= 1'b0;
         cmd_vld_o  <= 1'b0;
         dat_vld_o  <= 1'b0;
         cmd_done_o <= 1'b0;
         if (stby_evt) begin
            st_q   <= S_STBY;
            hold_q <= 1'b0;
         end else if (miss) begin
            st_q <= S_IDLE;
         end else begin
            if (mak_go)                 hold_q <= 1'b0;
            else if (hold_i && ack_slot) hold_q <= 1'b1;
            case (st_q)
               S_STBY:     if (start_evt) st_q <= S_SYNC;
               S_SYNC:     if (byte_vld_i)
                              st_q <= (byte_i == SYNC_PATTERN) ? S_SYNC_ACK : S_IDLE;
               S_SYNC_ACK: if (mak_go) st_q <= mak_i ? S_ADR1 : S_IDLE;
               S_ADR1:     if (byte_vld_i)
                              st_q <= a1_ok ? S_ADR_ACK : (a1_esc ? S_ADR1_ACK : S_IDLE);
               S_ADR1_ACK: if (mak_go) st_q <= mak_i ? S_ADR2 : S_IDLE;
               S_ADR2:     if (byte_vld_i) st_q <= a2_ok ? S_ADR_ACK : S_IDLE;
               S_ADR_ACK:  if (mak_go) begin
                              sak_o <= 1'b1;
                              st_q  <= mak_i ? S_CMD : S_STBY;
                           end
               S_CMD:      if (byte_vld_i) begin
                              if (lut_hit) begin
                                 cmd_vld_o <= 1'b1;
                                 byte_o    <= byte_i;
                                 cnt_q     <= lut_len;
                                 st_q      <= S_XFER_ACK;
                              end else begin
                                 st_q <= S_IDLE;
                              end
                           end
               S_DAT:      if (byte_vld_i) begin
                              if (cnt_q != '0) begin
                                 dat_vld_o <= 1'b1;
                                 byte_o    <= byte_i;
                                 cnt_q     <= cnt_q - 1'b1;
                                 st_q      <= S_XFER_ACK;
                              end else begin
                                 st_q <= S_IDLE;
                              end
                           end
               S_XFER_ACK: if (mak_go) begin
                              if (mak_i) begin
                                 sak_o <= 1'b1;
                                 st_q  <= S_DAT;
                              end else if (cnt_q == '0) begin
                                 sak_o      <= 1'b1;
                                 cmd_done_o <= 1'b1;
                                 st_q       <= S_STBY;
                              end else begin
                                 st_q <= S_IDLE;
                              end
                           end
               default:    ;
            endcase
         end
      end
   end

   always_comb begin
      case (st_q)
         S_IDLE:  mode_o = MD_IDLE;
         S_STBY:  mode_o = MD_STBY;
         default: mode_o = hold_q ? MD_HOLD : MD_ACTV;
      endcase
   end

   a_r13_sak_after_mak: assert property (@(posedge clk) disable iff (!rst_n)
      sak_o |-> $past(mak_vld_i));

   a_r13_handover_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_o || dat_vld_o) |-> $past(byte_vld_i));

   a_r1_idle_until_stby: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && !stby_evt) |=> (st_q == S_IDLE));

   a_r12_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !mak_vld_i && !stby_evt) |=> hold_q);

   a_r10_done_in_stby: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done_o |-> (mode_o == MD_STBY));

endmodule

// File: tb/swb_slave_ctrl_tb.sv
module swb_slave_ctrl_tb;
   localparam int TSTBY = 20;
   localparam int GAP   = 5;
   localparam int K_SAK = 0, K_CMD = 1, K_DAT = 2, K_DONE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_i = 1'b1;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       mak_vld_i = 1'b0, mak_i = 1'b0;
   logic       edge_miss_i = 1'b0, hold_i = 1'b0;
   logic [3:0] fam_i = 4'hA;
   logic [7:0] dev_i = 8'h35;

   logic [1:0] mode_o, mode_x;
   logic       sak_o, cmd_vld_o, dat_vld_o, cmd_done_o;
   logic       sak_x, cmd_vld_x, dat_vld_x, cmd_done_x;
   logic [7:0] byte_o, byte_x;

   int checks = 0, errors = 0, cyc = 0, ext_sak = 0;
   int q_kind[$], q_byte[$], q_cyc[$];
   string q_tag[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   swb_slave_ctrl #(.EXT_ADDR(1'b0), .TSTBY_CYC(TSTBY), .GAP_CYC(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
      .mak_vld_i(mak_vld_i), .mak_i(mak_i), .edge_miss_i(edge_miss_i), .hold_i(hold_i),
      .fam_i(fam_i), .dev_i(dev_i), .mode_o(mode_o), .sak_o(sak_o), .cmd_vld_o(cmd_vld_o),
      .dat_vld_o(dat_vld_o), .byte_o(byte_o), .cmd_done_o(cmd_done_o));

   swb_slave_ctrl #(.EXT_ADDR(1'b1), .TSTBY_CYC(TSTBY), .GAP_CYC(GAP)) u_dut_ext (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
      .mak_vld_i(mak_vld_i), .mak_i(mak_i), .edge_miss_i(edge_miss_i), .hold_i(hold_i),
      .fam_i(fam_i), .dev_i(dev_i), .mode_o(mode_x), .sak_o(sak_x), .cmd_vld_o(cmd_vld_x),
      .dat_vld_o(dat_vld_x), .byte_o(byte_x), .cmd_done_o(cmd_done_x));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input int b, input string tag);
      q_kind.push_back(kind); q_byte.push_back(b); q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
   endtask

   task automatic take(input int kind, input int b);
      int ek, eb, ec;
      string et;
      if (q_kind.size() == 0) begin
         chk(1'b0, "R13 unexpected output pulse", kind, -1);
         return;
      end
      ek = q_kind.pop_front(); eb = q_byte.pop_front(); ec = q_cyc.pop_front(); et = q_tag.pop_front();
      chk(ek == kind, {et, " event kind"}, kind, ek);
      chk(eb == b, {et, " byte"}, b, eb);
      chk(ec == cyc, {et, " R13 cycle"}, cyc, ec);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (sak_o)      take(K_SAK, 0);
         if (cmd_vld_o)  take(K_CMD, int'(byte_o));
         if (dat_vld_o)  take(K_DAT, int'(byte_o));
         if (cmd_done_o) take(K_DONE, 0);
         if (sak_x)      ext_sak++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_byte(input logic [7:0] b, input int kind, input string tag);
      @(posedge clk); #1;
      byte_vld_i = 1'b1; byte_i = b;
      if (kind >= 0) expect_ev(kind, int'(b), tag);
      @(posedge clk); #1;
      byte_vld_i = 1'b0;
      tick(2);
   endtask

   task automatic send_mak(input logic m, input bit exp_sak, input bit exp_done, input string tag);
      @(posedge clk); #1;
      mak_vld_i = 1'b1; mak_i = m;
      if (exp_sak)  expect_ev(K_SAK, 0, tag);
      if (exp_done) expect_ev(K_DONE, 0, tag);
      @(posedge clk); #1;
      mak_vld_i = 1'b0;
      tick(2);
   endtask

   task automatic pulse_in(input int which);
      @(posedge clk); #1;
      if (which == 0) edge_miss_i = 1'b1; else hold_i = 1'b1;
      @(posedge clk); #1;
      edge_miss_i = 1'b0; hold_i = 1'b0;
      tick(2);
   endtask

   task automatic stby_pulse();
      @(posedge clk); #1;
      line_i = 1'b0; tick(2);
      line_i = 1'b1; tick(TSTBY + 2 + GAP + 1);
   endtask

   task automatic begin_cmd();
      stby_pulse();
      line_i = 1'b0; tick(2);
   endtask

   task automatic mode_is(input int exp, input string tag);
      @(negedge clk);
      chk(int'(mode_o) == exp, tag, int'(mode_o), exp);
      tick(1);
   endtask

   initial begin
      int s0;
      tick(3);
      rst_n = 1'b1;
      // R1: reset state and no standby without a rising edge
      @(negedge clk);
      chk(mode_o == 2'd0 && !sak_o && !cmd_vld_o && !dat_vld_o && !cmd_done_o,
          "R1 reset state", int'(mode_o), 0);
      tick(TSTBY + 5);
      mode_is(0, "R1 high line without rise stays idle");

      // R2: threshold of the standby interval
      line_i = 1'b0; tick(2);
      line_i = 1'b1; tick(TSTBY - 2);
      mode_is(0, "R2 before threshold still idle");
      tick(3);
      mode_is(1, "R2 standby entered");

      // R3: early fall ignored, later fall starts
      stby_pulse();
      line_i = 1'b0; tick(1); line_i = 1'b1;
      begin : early_fall
         @(posedge clk); #1;
      end
      stby_pulse();
      line_i = 1'b0; tick(2);
      mode_is(2, "R3 fall after gap starts command");
      line_i = 1'b1; tick(2);
      // re-enter standby: pulse of TSTBY high
      tick(TSTBY);
      mode_is(1, "R2 standby from active");
      line_i = 1'b0; tick(2);
      mode_is(1, "R3 fall right after standby entry ignored");

      // R4/R5/R8/R9/R10: full 8-bit command 03 with two data bytes
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R5");
      send_mak(1'b1, 1, 0, "R5 address ack");
      send_byte(8'h03, K_CMD, "R8 command handover");
      send_mak(1'b1, 1, 0, "R8 command ack");
      send_byte(8'h11, K_DAT, "R9 data handover");
      send_mak(1'b1, 1, 0, "R9 data ack");
      send_byte(8'h22, K_DAT, "R9 data handover");
      send_mak(1'b0, 1, 1, "R10 complete");
      mode_is(1, "R10 standby after completion");

      // R7: polling
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R7");
      send_mak(1'b0, 1, 0, "R7 polling ack");
      mode_is(1, "R7 standby after poll");

      // R5: mismatch
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA6, -1, "R5");
      mode_is(0, "R5 mismatch to idle");
      send_mak(1'b1, 0, 0, "R5 no ack after mismatch");

      // R6: 12-bit address on the extended instance, escape idles the short one
      begin_cmd();
      s0 = ext_sak;
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hFA, -1, "R6");
      mode_is(0, "R5 escape family idles short-address slave");
      send_mak(1'b1, 0, 0, "R6");
      chk(ext_sak == s0, "R6 no ack after first address byte", ext_sak - s0, 0);
      send_byte(8'h35, -1, "R6");
      send_mak(1'b1, 0, 0, "R6");
      send_byte(8'h06, -1, "R6");
      send_mak(1'b0, 0, 0, "R6");
      chk(ext_sak - s0 == 2, "R6 extended slave acks", ext_sak - s0, 2);
      @(negedge clk);
      chk(int'(mode_x) == 1, "R6 extended slave completes", int'(mode_x), 1);

      // R4: bad sync and terminate after sync
      begin_cmd();
      send_byte(8'h54, -1, "R4");
      mode_is(0, "R4 bad sync to idle");
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b0, 0, 0, "R4");
      mode_is(0, "R4 terminate after sync to idle");

      // R8: invalid command
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R5");
      send_mak(1'b1, 1, 0, "R5 address ack");
      send_byte(8'h55, -1, "R8");
      mode_is(0, "R8 invalid command to idle");
      send_mak(1'b0, 0, 0, "R8 no ack");

      // R10: early terminate
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R5");
      send_mak(1'b1, 1, 0, "R5 address ack");
      send_byte(8'h03, K_CMD, "R8 command handover");
      send_mak(1'b1, 1, 0, "R8 command ack");
      send_byte(8'h11, K_DAT, "R9 data handover");
      send_mak(1'b0, 0, 0, "R10 short terminate");
      mode_is(0, "R10 short terminate to idle");

      // R9: too many data bytes
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R5");
      send_mak(1'b1, 1, 0, "R5 address ack");
      send_byte(8'h6C, K_CMD, "R8 command handover");
      send_mak(1'b1, 1, 0, "R8 command ack");
      send_byte(8'h44, K_DAT, "R9 data handover");
      send_mak(1'b1, 1, 0, "R9 data ack");
      send_byte(8'h45, -1, "R9");
      mode_is(0, "R9 extra data byte to idle");

      // R11: missed edge
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R5");
      send_mak(1'b1, 1, 0, "R5 address ack");
      pulse_in(0);
      mode_is(0, "R11 missed edge to idle");
      send_byte(8'h03, -1, "R11 no handover after error");

      // R12: hold
      begin_cmd();
      send_byte(8'h55, -1, "R4");
      send_mak(1'b1, 0, 0, "R4");
      send_byte(8'hA5, -1, "R12");
      pulse_in(1);
      mode_is(3, "R12 hold entered");
      pulse_in(0);
      mode_is(3, "R12 missed edge ignored in hold");
      send_mak(1'b0, 0, 0, "R12 terminate ignored in hold");
      mode_is(3, "R12 still hold");
      send_mak(1'b1, 1, 0, "R12 resume ack");
      mode_is(2, "R12 active after resume");
      send_byte(8'h06, K_CMD, "R8 command handover");
      send_mak(1'b0, 1, 1, "R10 zero-length complete");
      mode_is(1, "R10 standby after zero-length command");

      tick(4);
      chk(q_kind.size() == 0, "R13 all expected events seen", q_kind.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule